// File: doc/BRIEF.md
# Companion-Chip Register Access Bridge

This block sits between a host memory-mapped port and a companion power-management chip whose registers are 16 bits wide with 12-bit addresses. Host writes that fall inside a 4 KiB slave window are turned into write requests. These requests are queued in a small FIFO and sent one at a time over a downstream valid/ready request port. Host reads are posted. Software writes the target address to a read-command register, then polls a busy flag. When the flag drops, the returned 16-bit value sits beside the 12-bit address it belongs to, so a stale or mismatched answer can be spotted.

A small control set sits beside the window. It holds the FIFO flags and level, a sticky overflow flag, an addressing-mode field, a bit that forces the downstream clock enable on instead of letting it gate automatically, and enable bits for the hardware channels. A posted read never overtakes a write queued before it. The read waits until every earlier write has been handed downstream.

Top module: `pmic_reg_bridge`

## Requirements
- R1: After reset the FIFO status word (offset 0x30) reads 0x0000_0400 (empty). The read-data word (0x2C), control word (0x04), configuration word (0x20) and both channel-enable words read 0. `dn_req_valid` and `chan_en` are 0.
- R2: A host write to a byte offset from 0x8000 to 0x8FFF produces exactly one downstream write request (`dn_req_write`=1), carrying offset bits 11:0 and write-data bits 15:0. Requests leave in arrival order. Host writes at or above 0x9000, or below 0x8000, produce no request.
- R3: In the FIFO status word, bit 10 is the empty flag, bit 11 is the full flag and bits 9:0 are the number of queued entries. With the downstream port stalled, the FIFO reaches full at 8 entries, with one more request held on the port.
- R4: A window write while the FIFO is full is dropped and sets sticky bit 12 of the status word. The flag stays set after the FIFO drains. Writing the status word with bit 12 set clears it.
- R5: A host write to 0x28 starts a read of the address in write-data bits 11:0. Read-data bit 31 is set from the cycle after that write until the downstream response arrives. After completion, bits 15:0 hold the response, bits 27:16 hold the requested address and bits 30:28 are 0.
- R6: A posted read is not presented downstream until every window write accepted before it has been handed downstream.
- R7: A write to 0x28 while bit 31 of the read-data word is set is ignored. No second read is issued, and the reported address stays that of the first command.
- R8: While `dn_req_valid` is high and `dn_req_ready` is low, the request stays valid and its write flag, address and data stay unchanged.
- R9: Bit 30 of the configuration word reads back as written. When it is set, `clk_en` is 1. When it is clear, `clk_en` is 1 only while a request is queued or outstanding, or a read is busy.
- R10: Bits 31:2 of the word at 0x40 drive `chan_en[31:2]`, and bits 1:0 read 0. Bits 17:0 of the word at 0x20C drive `chan_en[49:32]`, and the upper bits read 0. `chan_en[1:0]` is always 0.
- R11: Bits 3:0 of the control word (0x04) read back as written, with 0 selecting 12-bit slave addressing. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Byte offset from the block base |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the addressed word, same cycle |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_write | output | 1 | 1 = write request, 0 = read request |
| dn_req_addr | output | 12 | Companion register address |
| dn_req_wdata | output | 16 | Write data |
| dn_rsp_valid | input | 1 | Read response strobe |
| dn_rsp_data | input | 16 | Read response data |
| clk_en | output | 1 | Downstream clock enable |
| chan_en | output | 50 | Hardware channel enables |

## Verification
The hardest case to reach is a posted read that arrives behind queued writes. The read command has to land while the request slot and the FIFO both hold writes, so that the read is forced to wait for the drain. The bench reaches this by stalling `dn_req_ready`, queueing writes and posting the read while still stalled. It then releases the port and checks that the read comes out last. A second stalled case posts two read commands back to back, so the second one meets a busy read. A third overfills the FIFO past its depth to reach the drop path.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;

  localparam int REG_AW = 12;
  localparam int REG_DW = 16;

  localparam logic [15:0] OFF_CTRL    = 16'h0004;
  localparam logic [15:0] OFF_CFG     = 16'h0020;
  localparam logic [15:0] OFF_RD_CMD  = 16'h0028;
  localparam logic [15:0] OFF_RD_DATA = 16'h002C;
  localparam logic [15:0] OFF_FIFO    = 16'h0030;
  localparam logic [15:0] OFF_CHAN_LO = 16'h0040;
  localparam logic [15:0] OFF_CHAN_HI = 16'h020C;

  localparam int FORCE_BIT = 30;
  localparam int OVF_BIT   = 12;

  typedef struct packed {
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] data;
  } wr_entry_t;

  typedef struct packed {
    logic              wr;
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] data;
  } dn_req_t;

  function automatic logic in_slave_win(input logic [15:0] a);
    return a[15:12] == 4'h8;
  endfunction

  function automatic logic [31:0] pack_rd_word(input logic busy,
                                               input logic [REG_AW-1:0] a,
                                               input logic [REG_DW-1:0] d);
    return {busy, 3'b000, a, d};
  endfunction

  function automatic logic [31:0] pack_fifo_word(input logic ovf, input logic full,
                                                 input logic empty, input logic [9:0] lvl);
    return {19'd0, ovf, full, empty, lvl};
  endfunction

endpackage

// File: rtl/pmic_bridge_fifo.sv
module pmic_bridge_fifo #(
  parameter int WIDTH = 28,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [LVL_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == LVL_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign level   = cnt_q;
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign dout    = mem_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/pmic_bridge_regs.sv
module pmic_bridge_regs
  import pmic_bridge_pkg::*;
#(
  parameter int NUM_CHAN = 50,
  localparam int HI_CH = NUM_CHAN - 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_req,
  input  logic                host_we,
  input  logic [15:0]         host_addr,
  input  logic [31:0]         host_wdata,
  output logic [31:0]         host_rdata,
  input  logic                fifo_full,
  input  logic                fifo_empty,
  input  logic [9:0]          fifo_level,
  input  logic                rd_busy,
  input  logic [REG_AW-1:0]   rd_echo,
  input  logic [REG_DW-1:0]   rd_value,
  output logic                win_wr,
  output logic                fifo_push,
  output wr_entry_t           push_entry,
  output logic                rd_cmd_wr,
  output logic [REG_AW-1:0]   rd_cmd_addr,
  output logic                ovf,
  output logic                ovf_clr,
  output logic                cfg_force,
  output logic [NUM_CHAN-1:0] chan_en
);

  logic             host_wr, host_rd;
  logic [3:0]       ctrl_q;
  logic             force_q;
  logic             ovf_q;
  logic [31:2]      chan_lo_q;
  logic [HI_CH-1:0] chan_hi_q;

  assign host_wr     = host_req & host_we;
  assign host_rd     = host_req & ~host_we;
  assign win_wr      = host_wr & in_slave_win(host_addr);
  assign fifo_push   = win_wr & ~fifo_full;
  assign push_entry  = '{addr: host_addr[REG_AW-1:0], data: host_wdata[REG_DW-1:0]};
  assign rd_cmd_wr   = host_wr & (host_addr == OFF_RD_CMD);
  assign rd_cmd_addr = host_wdata[REG_AW-1:0];
  assign ovf_clr     = host_wr & (host_addr == OFF_FIFO) & host_wdata[OVF_BIT];
  assign ovf         = ovf_q;
  assign cfg_force   = force_q;
  assign chan_en     = {chan_hi_q, chan_lo_q, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      force_q   <= 1'b0;
      ovf_q     <= 1'b0;
      chan_lo_q <= '0;
      chan_hi_q <= '0;
    end else begin
      if (win_wr && fifo_full) ovf_q <= 1'b1;
      else if (ovf_clr)        ovf_q <= 1'b0;
      if (host_wr) begin
        case (host_addr)
          OFF_CTRL:    ctrl_q    <= host_wdata[3:0];
          OFF_CFG:     force_q   <= host_wdata[FORCE_BIT];
          OFF_CHAN_LO: chan_lo_q <= host_wdata[31:2];
          OFF_CHAN_HI: chan_hi_q <= host_wdata[HI_CH-1:0];
          default:     ;
        endcase
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      case (host_addr)
        OFF_CTRL:    host_rdata = {28'd0, ctrl_q};
        OFF_CFG:     host_rdata = {1'b0, force_q, 30'd0};
        OFF_RD_DATA: host_rdata = pack_rd_word(rd_busy, rd_echo, rd_value);
        OFF_FIFO:    host_rdata = pack_fifo_word(ovf_q, fifo_full, fifo_empty, fifo_level);
        OFF_CHAN_LO: host_rdata = {chan_lo_q, 2'b00};
        OFF_CHAN_HI: host_rdata = 32'(chan_hi_q);
        default:     host_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/pmic_bridge_sched.sv
module pmic_bridge_sched
  import pmic_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  wr_entry_t         fifo_head,
  output logic              fifo_pop,
  input  logic              rd_cmd_wr,
  input  logic [REG_AW-1:0] rd_cmd_addr,
  input  logic              dn_req_ready,
  input  logic              dn_rsp_valid,
  input  logic [REG_DW-1:0] dn_rsp_data,
  output logic              dn_req_valid,
  output dn_req_t           dn_req,
  output logic              rd_busy,
  output logic              rd_load,
  output logic [REG_AW-1:0] rd_echo,
  output logic [REG_DW-1:0] rd_value
);

  logic              slot_v_q;
  dn_req_t           slot_q;
  logic              rd_pend_q, rd_issued_q;
  logic [REG_AW-1:0] rd_addr_q;
  logic [REG_DW-1:0] rd_val_q;
  logic              slot_free, wr_load, rd_accept, rd_done;

  assign slot_free = ~slot_v_q | dn_req_ready;
  assign wr_load   = slot_free & ~fifo_empty;
  assign rd_load   = slot_free & fifo_empty & rd_pend_q & ~rd_issued_q;
  assign rd_accept = rd_cmd_wr & ~rd_pend_q;
  assign rd_done   = rd_issued_q & dn_rsp_valid;
  assign fifo_pop  = wr_load;

  assign dn_req_valid = slot_v_q;
  assign dn_req       = slot_q;
  assign rd_busy      = rd_pend_q;
  assign rd_echo      = rd_addr_q;
  assign rd_value     = rd_val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v_q <= 1'b0;
      slot_q   <= '0;
    end else if (wr_load) begin
      slot_v_q <= 1'b1;
      slot_q   <= '{wr: 1'b1, addr: fifo_head.addr, data: fifo_head.data};
    end else if (rd_load) begin
      slot_v_q <= 1'b1;
      slot_q   <= '{wr: 1'b0, addr: rd_addr_q, data: '0};
    end else if (dn_req_ready) begin
      slot_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q   <= 1'b0;
      rd_issued_q <= 1'b0;
      rd_addr_q   <= '0;
      rd_val_q    <= '0;
    end else begin
      if (rd_accept) begin
        rd_pend_q <= 1'b1;
        rd_addr_q <= rd_cmd_addr;
      end
      if (rd_load) rd_issued_q <= 1'b1;
      if (rd_done) begin
        rd_pend_q   <= 1'b0;
        rd_issued_q <= 1'b0;
        rd_val_q    <= dn_rsp_data;
      end
    end
  end

endmodule

// File: rtl/pmic_reg_bridge.sv
module pmic_reg_bridge
  import pmic_bridge_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int NUM_CHAN   = 50,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_req,
  input  logic                host_we,
  input  logic [15:0]         host_addr,
  input  logic [31:0]         host_wdata,
  output logic [31:0]         host_rdata,
  output logic                dn_req_valid,
  input  logic                dn_req_ready,
  output logic                dn_req_write,
  output logic [11:0]         dn_req_addr,
  output logic [15:0]         dn_req_wdata,
  input  logic                dn_rsp_valid,
  input  logic [15:0]         dn_rsp_data,
  output logic                clk_en,
  output logic [NUM_CHAN-1:0] chan_en
);

  logic              fifo_full_w, fifo_empty_w, fifo_push_w, fifo_pop_w;
  logic [LVL_W-1:0]  fifo_level_w;
  wr_entry_t         push_entry_w, fifo_head_w;
  logic              win_wr_w, rd_cmd_wr_w, ovf_w, ovf_clr_w, cfg_force_w;
  logic [REG_AW-1:0] rd_cmd_addr_w, rd_echo_w;
  logic [REG_DW-1:0] rd_value_w;
  logic              rd_busy_w, rd_load_w;
  dn_req_t           dn_req_w;

  pmic_bridge_regs #(.NUM_CHAN(NUM_CHAN)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .fifo_full   (fifo_full_w),
    .fifo_empty  (fifo_empty_w),
    .fifo_level  (10'(fifo_level_w)),
    .rd_busy     (rd_busy_w),
    .rd_echo     (rd_echo_w),
    .rd_value    (rd_value_w),
    .win_wr      (win_wr_w),
    .fifo_push   (fifo_push_w),
    .push_entry  (push_entry_w),
    .rd_cmd_wr   (rd_cmd_wr_w),
    .rd_cmd_addr (rd_cmd_addr_w),
    .ovf         (ovf_w),
    .ovf_clr     (ovf_clr_w),
    .cfg_force   (cfg_force_w),
    .chan_en     (chan_en)
  );

  pmic_bridge_fifo #(.WIDTH($bits(wr_entry_t)), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push_w),
    .din   (push_entry_w),
    .pop   (fifo_pop_w),
    .dout  (fifo_head_w),
    .full  (fifo_full_w),
    .empty (fifo_empty_w),
    .level (fifo_level_w)
  );

  pmic_bridge_sched sched_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_empty   (fifo_empty_w),
    .fifo_head    (fifo_head_w),
    .fifo_pop     (fifo_pop_w),
    .rd_cmd_wr    (rd_cmd_wr_w),
    .rd_cmd_addr  (rd_cmd_addr_w),
    .dn_req_ready (dn_req_ready),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_data  (dn_rsp_data),
    .dn_req_valid (dn_req_valid),
    .dn_req       (dn_req_w),
    .rd_busy      (rd_busy_w),
    .rd_load      (rd_load_w),
    .rd_echo      (rd_echo_w),
    .rd_value     (rd_value_w)
  );

  assign dn_req_write = dn_req_w.wr;
  assign dn_req_addr  = dn_req_w.addr;
  assign dn_req_wdata = dn_req_w.data;
  assign clk_en       = cfg_force_w | ~fifo_empty_w | dn_req_valid | rd_busy_w;

endmodule

// File: rtl/pmic_reg_bridge_chk.sv
module pmic_reg_bridge_chk #(
  parameter int NUM_CHAN = 50
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dn_req_valid,
  input logic                dn_req_ready,
  input logic                dn_req_write,
  input logic [11:0]         dn_req_addr,
  input logic [15:0]         dn_req_wdata,
  input logic                dn_rsp_valid,
  input logic                fifo_empty_w,
  input logic                fifo_full_w,
  input logic                rd_load_w,
  input logic                rd_busy_w,
  input logic                rd_cmd_wr_w,
  input logic                ovf_w,
  input logic                ovf_clr_w,
  input logic                win_wr_w,
  input logic                cfg_force_w,
  input logic                clk_en,
  input logic [NUM_CHAN-1:0] chan_en
);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_write)
      && $stable(dn_req_addr) && $stable(dn_req_wdata));

  // R6
  rd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load_w |-> fifo_empty_w);

  // R3
  fifo_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full_w |-> !fifo_empty_w);

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_w && !ovf_clr_w |=> ovf_w);

  // R4
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_w) |-> $past(win_wr_w && fifo_full_w));

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_busy_w) |-> $past(rd_cmd_wr_w));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy_w && !dn_rsp_valid |=> rd_busy_w);

  // R9
  clk_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_force_w |-> clk_en);

  // R10
  sw_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en[1:0] == 2'b00);

endmodule

bind pmic_reg_bridge pmic_reg_bridge_chk #(.NUM_CHAN(NUM_CHAN)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .dn_req_valid (dn_req_valid),
  .dn_req_ready (dn_req_ready),
  .dn_req_write (dn_req_write),
  .dn_req_addr  (dn_req_addr),
  .dn_req_wdata (dn_req_wdata),
  .dn_rsp_valid (dn_rsp_valid),
  .fifo_empty_w (fifo_empty_w),
  .fifo_full_w  (fifo_full_w),
  .rd_load_w    (rd_load_w),
  .rd_busy_w    (rd_busy_w),
  .rd_cmd_wr_w  (rd_cmd_wr_w),
  .ovf_w        (ovf_w),
  .ovf_clr_w    (ovf_clr_w),
  .win_wr_w     (win_wr_w),
  .cfg_force_w  (cfg_force_w),
  .clk_en       (clk_en),
  .chan_en      (chan_en)
);

// File: tb/pmic_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module pmic_reg_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        dn_req_valid, dn_req_write;
  logic        dn_req_ready = 1'b1;
  logic [11:0] dn_req_addr;
  logic [15:0] dn_req_wdata;
  logic        dn_rsp_valid = 1'b0;
  logic [15:0] dn_rsp_data = '0;
  logic        clk_en;
  logic [49:0] chan_en;

  int n_checks = 0;
  int n_err = 0;
  logic [28:0] log_q [0:255];
  int log_n = 0;
  int rsp_cnt = 0;
  logic [15:0] rsp_val = '0;

  always #2 clk = ~clk;

  pmic_reg_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_req_write(dn_req_write), .dn_req_addr(dn_req_addr),
    .dn_req_wdata(dn_req_wdata), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_data(dn_rsp_data), .clk_en(clk_en), .chan_en(chan_en)
  );

  // companion-chip model: answers reads with a value derived from the address
  function automatic logic [15:0] chip_value(input logic [11:0] a);
    return {a, 4'h0} ^ 16'h3C5A;
  endfunction

  always begin
    @(negedge clk);
    dn_rsp_valid = 1'b0;
    if (rsp_cnt == 1) begin
      dn_rsp_valid = 1'b1;
      dn_rsp_data  = rsp_val;
    end
    if (rsp_cnt > 0) rsp_cnt = rsp_cnt - 1;
    #1;
    if (rst_n && dn_req_valid && dn_req_ready) begin
      if (log_n < 256) log_q[log_n] = {dn_req_write, dn_req_addr, dn_req_wdata};
      log_n = log_n + 1;
      if (!dn_req_write) begin
        rsp_cnt = 3;
        rsp_val = chip_value(dn_req_addr);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic hrd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    #1 d = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_not_busy(output logic [31:0] d);
    for (int i = 0; i < 60; i++) begin
      hrd(16'h002C, d);
      if (!d[31]) break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    hrd(16'h0030, d); check("R1 fifo status", d, 32'h0000_0400);
    hrd(16'h002C, d); check("R1 read data", d, 32'h0);
    hrd(16'h0004, d); check("R1 ctrl", d, 32'h0);
    hrd(16'h0020, d); check("R1 cfg", d, 32'h0);
    hrd(16'h0040, d); check("R1 chan lo", d, 32'h0);
    hrd(16'h020C, d); check("R1 chan hi", d, 32'h0);
    check("R1 req valid", 32'(dn_req_valid), 32'h0);
    check("R1 chan_en", 32'(chan_en[31:0] | 32'(chan_en[49:32])), 32'h0);
  endtask

  task automatic t_window_writes;
    int base;
    dn_req_ready = 1'b1;
    base = log_n;
    hwr(16'h8010, 32'hDEAD_1234);
    hwr(16'h8FFE, 32'h0000_ABCD);
    hwr(16'h9000, 32'h0000_1111);
    hwr(16'h7FFC, 32'h0000_2222);
    hwr(16'h8000, 32'h0000_0042);
    idle(10);
    check("R2 request count", 32'(log_n - base), 32'd3);
    check("R2 first", 32'(log_q[base]),   32'({1'b1, 12'h010, 16'h1234}));
    check("R2 second", 32'(log_q[base+1]), 32'({1'b1, 12'hFFE, 16'hABCD}));
    check("R2 third", 32'(log_q[base+2]), 32'({1'b1, 12'h000, 16'h0042}));
  endtask

  task automatic t_fifo_full;
    logic [31:0] d;
    logic [11:0] held;
    int base;
    dn_req_ready = 1'b0;
    base = log_n;
    for (int i = 0; i < 9; i++) hwr(16'h8100 + 16'(i * 2), 32'(16'h0A00 + i));
    hrd(16'h0030, d); check("R3 full at depth", d, 32'h0000_0808);
    held = dn_req_addr;
    idle(3);
    check("R8 held valid", 32'(dn_req_valid), 32'h1);
    check("R8 held addr", 32'(dn_req_addr), 32'(held));
    check("R8 held addr value", 32'(held), 32'h100);
    hwr(16'h8200, 32'h0000_0BAD);
    hrd(16'h0030, d); check("R4 overflow set", d, 32'h0000_1808);
    dn_req_ready = 1'b1;
    idle(20);
    check("R4 dropped write count", 32'(log_n - base), 32'd9);
    check("R4 last kept", 32'(log_q[base+8]), 32'({1'b1, 12'h110, 16'h0A08}));
    hrd(16'h0030, d); check("R4 sticky after drain", d, 32'h0000_1400);
    hwr(16'h0030, 32'h0000_1000);
    hrd(16'h0030, d); check("R4 cleared", d, 32'h0000_0400);
  endtask

  task automatic t_read;
    logic [31:0] d;
    dn_req_ready = 1'b1;
    hwr(16'h0028, 32'h0000_8123);
    hrd(16'h002C, d); check("R5 busy set", 32'(d[31]), 32'h1);
    wait_not_busy(d);
    check("R5 read result", d, {1'b0, 3'b000, 12'h123, chip_value(12'h123)});
  endtask

  task automatic t_raw;
    logic [31:0] d;
    int base;
    dn_req_ready = 1'b0;
    base = log_n;
    hwr(16'h8300, 32'h0000_0001);
    hwr(16'h8302, 32'h0000_0002);
    hwr(16'h8304, 32'h0000_0003);
    hwr(16'h0028, 32'h0000_8044);
    idle(4);
    check("R6 nothing sent while stalled", 32'(log_n - base), 32'd0);
    dn_req_ready = 1'b1;
    wait_not_busy(d);
    check("R6 total requests", 32'(log_n - base), 32'd4);
    check("R6 write 1 first", 32'(log_q[base]),   32'({1'b1, 12'h300, 16'h0001}));
    check("R6 write 3 before read", 32'(log_q[base+2]), 32'({1'b1, 12'h304, 16'h0003}));
    check("R6 read last", 32'(log_q[base+3]), 32'({1'b0, 12'h044, 16'h0000}));
    check("R6 read data", d, {1'b0, 3'b000, 12'h044, chip_value(12'h044)});
  endtask

  task automatic t_busy_ignore;
    logic [31:0] d;
    int base;
    dn_req_ready = 1'b0;
    base = log_n;
    hwr(16'h0028, 32'h0000_8011);
    hwr(16'h0028, 32'h0000_8022);
    dn_req_ready = 1'b1;
    wait_not_busy(d);
    idle(10);
    check("R7 single read issued", 32'(log_n - base), 32'd1);
    check("R7 first address kept", d, {1'b0, 3'b000, 12'h011, chip_value(12'h011)});
  endtask

  task automatic t_clock;
    logic [31:0] d;
    idle(4);
    check("R9 idle gated", 32'(clk_en), 32'h0);
    dn_req_ready = 1'b0;
    hwr(16'h8400, 32'h0000_0055);
    check("R9 busy enabled", 32'(clk_en), 32'h1);
    dn_req_ready = 1'b1;
    idle(5);
    check("R9 gated after drain", 32'(clk_en), 32'h0);
    hwr(16'h0020, 32'h4000_0000);
    hrd(16'h0020, d); check("R9 force readback", d, 32'h4000_0000);
    check("R9 forced on", 32'(clk_en), 32'h1);
    hwr(16'h0020, 32'h0000_0000);
    idle(1);
    check("R9 force released", 32'(clk_en), 32'h0);
  endtask

  task automatic t_chan;
    logic [31:0] d;
    hwr(16'h0040, 32'hFFFF_FFFF);
    hrd(16'h0040, d); check("R10 lo readback", d, 32'hFFFF_FFFC);
    check("R10 lo pins", chan_en[31:0], 32'hFFFF_FFFC);
    hwr(16'h020C, 32'hFFFF_FFFF);
    hrd(16'h020C, d); check("R10 hi readback", d, 32'h0003_FFFF);
    check("R10 hi pins", 32'(chan_en[49:32]), 32'h0003_FFFF);
    hwr(16'h0040, 32'h0000_0005);
    check("R10 sw channels zero", 32'(chan_en[3:0]), 32'h4);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    hwr(16'h0004, 32'hFFFF_FFF5);
    hrd(16'h0004, d); check("R11 ctrl readback", d, 32'h5);
    hwr(16'h0004, 32'h0);
    hrd(16'h0004, d); check("R11 ctrl zero", d, 32'h0);
    hrd(16'h0100, d); check("R11 unmapped", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_window_writes();
    t_fifo_full();
    t_read();
    t_raw();
    t_busy_ignore();
    t_clock();
    t_chan();
    t_ctrl();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule